// File: doc/BRIEF.md
# MII Management Register Responder

This block sits behind a 32-bit register bus and stands in for a station-management path to an Ethernet PHY. Software writes a command word to one management register and then reads the same register back. The block never drives a serial management line. It decodes the stored command and builds the reply on the spot from fixed values: a status word that reports link up and autonegotiation complete, the two halves of a 32-bit PHY identifier, or a bare "read data valid" flag.

Command word fields, from bit 0 upward:
- bits 15:0 hold data.
- bits 25:16 hold a combined PHY/register selector.
- bit 26 requests a read.
- bit 27 is the read-valid flag in the reply.
- bits 31:28 are not used.

Status and identity reads complete at once, so a driver's poll for the valid flag ends on its first read.

Top module: `mii_mgmt_responder`

## Requirements
- R1: After reset the stored command is zero. A read of the management register then returns 0x00000000, and `bus_rvalid` and `bus_rdata` are low.
- R2: A write with `bus_valid` and `bus_write` high at offset 0x010 stores all 32 bits of `bus_wdata` as the command. Later reads are decoded from this value.
- R3: When bit 26 of the stored command is 0, a read of the management register returns 0x00000000, whatever the other bits hold.
- R4: When bit 26 is set and bits 25:16 equal 0x021, a read returns 0x0800000C. Bit 27 is set, and bits 3:2 report link up and autonegotiation complete.
- R5: When bit 26 is set and bits 25:16 equal 0x041, a read returns 0x08000141. This is bit 27 plus the upper identifier half of 0x01410E20.
- R6: When bit 26 is set and bits 25:16 equal 0x061, a read returns 0x08000E20. This is bit 27 plus the lower identifier half.
- R7: When bit 26 is set and bits 25:16 hold any other value, a read returns 0x08000000. The stored data bits 15:0, bit 27 and bits 31:28 never change a reply.
- R8: A write to any other offset leaves the stored command unchanged. So does a cycle where `bus_write` is high but `bus_valid` is low.
- R9: A read at any offset other than 0x010 returns 0x00000000.
- R10: A read request (`bus_valid` high, `bus_write` low) gives `bus_rvalid` high with the reply on `bus_rdata` one clock later. Reads have no side effects, so repeated reads return the same word.
- R11: Write cycles and idle cycles give `bus_rvalid` low and `bus_rdata` zero on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read reply, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read reply strobe, one clock after the request |

## Verification
The reply decoder is exercised with a table of command words:
- The opcode bit is clear while the selector holds a known address, which separates the gating on bit 26 from the address decode.
- Each of the three known selectors is tried, which shows whether the status and identity values are crossed.
- Neighbouring and all-ones selectors are tried, which exposes a decode that matches too few bits.
- Noise is placed in the data field, bit 27 and the top nibble, which reveals any leak of stored bits into the reply.

Directed sequences then cover:
- writes that miss the offset or lack the strobe;
- reads at a foreign offset;
- back-to-back repeated reads;
- a reset issued while a command is held.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  localparam int WORD_W = 32;
  localparam int SEL_W  = 10;
  localparam int HALF_W = 16;

  typedef struct packed {
    logic [3:0]        spare;
    logic              valid_flag;
    logic              op_read;
    logic [SEL_W-1:0]  sel;
    logic [HALF_W-1:0] data;
  } mgmt_cmd_t;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ID_HI  = 2'd1,
    SEL_ID_LO  = 2'd2,
    SEL_OTHER  = 2'd3
  } mgmt_sel_e;

  // Put the read-valid flag (bit 27) on top of a 16-bit payload.
  function automatic logic [WORD_W-1:0] mk_reply(input logic [HALF_W-1:0] payload);
    logic [WORD_W-1:0] w;
    w     = '0;
    w[27] = 1'b1;
    w[HALF_W-1:0] = payload;
    return w;
  endfunction

endpackage

// File: rtl/mii_mgmt_cmd_reg.sv
module mii_mgmt_cmd_reg
  import mii_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [31:0] wr_data,
  output mgmt_cmd_t   cmd_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (wr_hit) cmd_q <= mgmt_cmd_t'(wr_data);
  end

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cmd_q == $past(wr_data)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cmd_q));

endmodule

// File: rtl/mii_mgmt_reply.sv
module mii_mgmt_reply
  import mii_mgmt_pkg::*;
#(
  parameter logic [31:0] PHY_ID     = 32'h0141_0E20,
  parameter logic [15:0] LINK_WORD  = 16'h000C,
  parameter logic [9:0]  STATUS_SEL = 10'h021,
  parameter logic [9:0]  IDHI_SEL   = 10'h041,
  parameter logic [9:0]  IDLO_SEL   = 10'h061
)(
  input  logic        clk,
  input  logic        rst_n,
  input  mgmt_cmd_t   cmd,
  output logic [31:0] reply,
  output logic        hit_status,
  output logic        hit_id_hi,
  output logic        hit_id_lo,
  output logic        hit_other
);

  mgmt_sel_e sel_kind;
  logic      unused_cmd_bits;

  assign unused_cmd_bits = ^{cmd.spare, cmd.valid_flag, cmd.data};

  always_comb begin
    if      (cmd.sel == STATUS_SEL) sel_kind = SEL_STATUS;
    else if (cmd.sel == IDHI_SEL)   sel_kind = SEL_ID_HI;
    else if (cmd.sel == IDLO_SEL)   sel_kind = SEL_ID_LO;
    else                            sel_kind = SEL_OTHER;
  end

  assign hit_status = cmd.op_read && (sel_kind == SEL_STATUS);
  assign hit_id_hi  = cmd.op_read && (sel_kind == SEL_ID_HI);
  assign hit_id_lo  = cmd.op_read && (sel_kind == SEL_ID_LO);
  assign hit_other  = cmd.op_read && (sel_kind == SEL_OTHER);

  always_comb begin
    reply = '0;
    unique case (1'b1)
      hit_status: reply = mk_reply(LINK_WORD);
      hit_id_hi:  reply = mk_reply(PHY_ID[31:16]);
      hit_id_lo:  reply = mk_reply(PHY_ID[15:0]);
      hit_other:  reply = mk_reply(16'h0000);
      default:    reply = '0;
    endcase
  end

  assert_one_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.op_read |-> ($countones({hit_status, hit_id_hi, hit_id_lo, hit_other}) == 1));

  assert_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.op_read |-> $onehot0({hit_status, hit_id_hi, hit_id_lo, hit_other}) &&
                     !(hit_status || hit_id_hi || hit_id_lo || hit_other));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.op_read |-> reply[27]);

endmodule

// File: rtl/mii_mgmt_responder.sv
module mii_mgmt_responder
  import mii_mgmt_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] MGMT_OFS   = 12'h010,
  parameter logic [31:0] PHY_ID     = 32'h0141_0E20,
  parameter logic [15:0] LINK_WORD  = 16'h000C
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(MGMT_OFS);

  logic        addr_hit;
  logic        wr_hit;
  logic        rd_req;
  logic        rd_hit;
  mgmt_cmd_t   cmd_q;
  logic [31:0] reply;
  logic        hit_status, hit_id_hi, hit_id_lo, hit_other;

  assign addr_hit = (bus_addr == OFS);
  assign wr_hit   = bus_valid && bus_write && addr_hit;
  assign rd_req   = bus_valid && !bus_write;
  assign rd_hit   = rd_req && addr_hit;

  mii_mgmt_cmd_reg u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_data (bus_wdata),
    .cmd_q   (cmd_q)
  );

  mii_mgmt_reply #(
    .PHY_ID    (PHY_ID),
    .LINK_WORD (LINK_WORD)
  ) u_reply (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd_q),
    .reply      (reply),
    .hit_status (hit_status),
    .hit_id_hi  (hit_id_hi),
    .hit_id_lo  (hit_id_lo),
    .hit_other  (hit_other)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_hit ? reply : '0;
    end
  end

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!bus_rvalid && bus_rdata == '0));

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !addr_hit) |=> (bus_rdata == '0));

  assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && hit_status) |=> (bus_rdata[27] && bus_rdata[15:0] == LINK_WORD));

endmodule

// File: tb/test_mii_mgmt_responder.sv
module test_mii_mgmt_responder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mii_mgmt_responder i_mii_mgmt_responder (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  localparam int NV = 11;
  localparam logic [31:0] CMD_TBL [NV] = '{
    32'h0000_0000, 32'h0021_0000, 32'h0421_0000, 32'h0441_0000,
    32'h0461_0000, 32'h0461_ABCD, 32'h0C21_FFFF, 32'h0422_0000,
    32'h07FF_0000, 32'hF421_0000, 32'hFBFF_FFFF
  };
  localparam logic [31:0] EXP_TBL [NV] = '{
    32'h0000_0000, 32'h0000_0000, 32'h0800_000C, 32'h0800_0141,
    32'h0800_0E20, 32'h0800_0E20, 32'h0800_000C, 32'h0800_0000,
    32'h0800_0000, 32'h0800_000C, 32'h0000_0000
  };

  function automatic string tag_for(input logic [31:0] c);
    if (!c[26])               return "R3";
    if (c[25:16] == 10'h021)  return "R4";
    if (c[25:16] == 10'h041)  return "R5";
    if (c[25:16] == 10'h061)  return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic v = 1'b1);
    @(negedge clk);
    bus_valid = v; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rst_n = 1'b1;
    bus_rd(12'h010, d, v);
    check("R1 read after reset", d, 32'h0);

    // Table walk: R2 store plus decode R3..R7
    for (int i = 0; i < NV; i++) begin
      bus_wr(12'h010, CMD_TBL[i]);
      bus_rd(12'h010, d, v);
      check({tag_for(CMD_TBL[i]), " via R2 store"}, d, EXP_TBL[i]);
      check("R10 rvalid", {31'd0, v}, 32'd1);
    end

    // R8: foreign-offset write and strobe-less write ignored
    bus_wr(12'h010, 32'h0441_0000);
    bus_wr(12'h014, 32'h0000_0000);
    bus_rd(12'h010, d, v);
    check("R8 foreign offset", d, 32'h0800_0141);
    bus_wr(12'h010, 32'h0000_0000, 1'b0);
    bus_rd(12'h010, d, v);
    check("R8 no strobe", d, 32'h0800_0141);

    // R9: read at another offset
    bus_rd(12'h014, d, v);
    check("R9 other offset", d, 32'h0);
    check("R9 rvalid", {31'd0, v}, 32'd1);

    // R10: repeated reads identical
    bus_wr(12'h010, 32'h0461_0000);
    bus_rd(12'h010, d, v);
    bus_rd(12'h010, d2, v);
    check("R10 repeat read", d2, d);
    check("R10 value", d2, 32'h0800_0E20);

    // R11: write cycle and idle give no reply
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h010; bus_wdata = 32'h0421_0000;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R11 rvalid after write", {31'd0, bus_rvalid}, 32'd0);
    check("R11 rdata after write", bus_rdata, 32'd0);
    @(negedge clk);
    check("R11 idle rvalid", {31'd0, bus_rvalid}, 32'd0);

    // R1: reset while a command is held
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_rd(12'h010, d, v);
    check("R1 command cleared", d, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule